// File: doc/BRIEF.md
# Instruction Bundle Slot Dispersal Unit

This block takes one 128-bit instruction bundle per cycle over a valid/ready handshake. It splits the bundle into a 5-bit template code and three 41-bit instruction slots. The template code alone decides which kind of functional unit each slot goes to: memory (M), integer (I), floating point (F), branch (B), or a long-immediate pair (L) built from two slots. The code also decides where the instruction-group stops fall. No opcode inspection and no dependency check is needed.

Each slot is routed to a lane of the port for its unit type. Lanes of one type fill in slot order, so the first M slot goes to M lane 0 and the second to M lane 1. Every lane carries the slot index and a marker that says a stop follows that slot. The routed bundle sits in one output register stage. The whole bundle leaves in a single cycle, once every port that carries one of its slots is ready.

The control is a two-state machine, EMPTY and LOADED:
- EMPTY goes to LOADED when a legal bundle is accepted (transition *load*).
- LOADED goes back to EMPTY when the held bundle drains and no new legal bundle arrives (transition *drain*).
- LOADED stays LOADED when a drain and a legal accept happen in the same cycle (transition *refill*).
- LOADED stays LOADED while a used port is not ready (transition *stall*).
- In EMPTY, an illegal bundle or no bundle leaves the state unchanged (transition *idle*).

Top module: `bundle_disperse`

## Requirements
- R1: The bundle fields are laid out as follows: template in bits [4:0], slot 0 in [45:5], slot 1 in [86:46] and slot 2 in [127:87]. Each slot's 41 bits appear unchanged on the lane it is routed to.
- R2: The template code, with bit 0 ignored, selects the slot types (slot0,slot1,slot2): 0x00/01 MII, 0x02/03 MII, 0x04/05 MLX, 0x08/09 MMI, 0x0A/0B MMI, 0x0C/0D MFI, 0x0E/0F MMF, 0x10/11 MIB, 0x12/13 MBB, 0x16/17 BBB, 0x18/19 MMB, 0x1C/1D MFB. Slots of one type fill that type's lanes from lane 0 upward in slot order. Lanes are packed with lane k at bits [41k+40:41k] of the slot bus, and each valid bus has one bit per lane. Unused lanes have valid low and data, index and stop equal to zero.
- R3: A lane's stop bit is set when a stop follows its slot. Codes 0x02/03 put a stop after slot 1. Codes 0x0A/0B put a stop after slot 0. An odd code puts a stop after slot 2.
- R4: For 0x04/05, slot 0 goes to M lane 0. Slots 1 and 2 leave together on the long port as {slot2, slot1} (82 bits). The long port's stop bit equals template bit 0.
- R5: Each lane's index field holds the number (0, 1 or 2) of the slot it carries, 2 bits per lane, packed like the data.
- R6: Any other template code is reserved. The bundle is accepted and dropped. `bad_bundle` is high for exactly the one cycle after acceptance, and no lane valid rises.
- R7: A bundle accepted at a clock edge appears on the output ports just after that edge, which is one cycle of latency.
- R8: A held bundle leaves only when every port that has a valid lane is ready. Until then its outputs hold and `in_ready` is low. The ready input of a port that carries no lane of the held bundle has no effect.
- R9: After reset all lane valids and `bad_bundle` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bundle offered |
| in_ready | output | 1 | Bundle taken on this edge when in_valid is high |
| in_bundle | input | 128 | Instruction bundle |
| bad_bundle | output | 1 | Reserved template was dropped |
| mem_valid | output | 2 | Memory lane valids |
| mem_ready | input | 1 | Memory port ready |
| mem_slot | output | 82 | Memory lane slots |
| mem_idx | output | 4 | Memory lane slot indices |
| mem_stop | output | 2 | Memory lane stop markers |
| int_valid | output | 2 | Integer lane valids |
| int_ready | input | 1 | Integer port ready |
| int_slot | output | 82 | Integer lane slots |
| int_idx | output | 4 | Integer lane slot indices |
| int_stop | output | 2 | Integer lane stop markers |
| fp_valid | output | 1 | Floating-point lane valid |
| fp_ready | input | 1 | Floating-point port ready |
| fp_slot | output | 41 | Floating-point slot |
| fp_idx | output | 2 | Floating-point slot index |
| fp_stop | output | 1 | Floating-point stop marker |
| br_valid | output | 3 | Branch lane valids |
| br_ready | input | 1 | Branch port ready |
| br_slot | output | 123 | Branch lane slots |
| br_idx | output | 6 | Branch lane slot indices |
| br_stop | output | 3 | Branch lane stop markers |
| lng_valid | output | 1 | Long-immediate pair valid |
| lng_ready | input | 1 | Long-immediate port ready |
| lng_slot | output | 82 | {slot2, slot1} of the long bundle |
| lng_stop | output | 1 | Stop after the long pair |

## Verification
The bench sends every legal code and several reserved ones, each with slot contents that differ per slot. A design that swapped slot order or miscounted lane ranks would put the wrong data on a lane. A design that ignored bit 0 or the mid-bundle stop codes would show the wrong stop bits. The long-pair bundle is checked for a swapped {slot2, slot1} join, and reserved codes are checked for leaking a valid.

Stall tests hold back one used port and check that the bundle freezes and `in_ready` drops. They then drop the ready of a port the bundle does not use, which must not hold anything back. A design that ANDed every ready together would stall there, and one that checked only some ports would release too early.

// File: rtl/disperse_pkg.sv
package disperse_pkg;
    parameter int TMPL_W  = 5;
    parameter int SLOT_W  = 41;
    parameter int NSLOT   = 3;
    parameter int BUNDLE_W = TMPL_W + NSLOT * SLOT_W;
    parameter int M_LANES = 2;
    parameter int I_LANES = 2;
    parameter int F_LANES = 1;
    parameter int B_LANES = 3;
    parameter int IDX_W   = $clog2(NSLOT);

    typedef enum logic [2:0] {
        UT_M, UT_I, UT_F, UT_B, UT_L, UT_X
    } unit_t;

    typedef unit_t [NSLOT-1:0] utrip_t;

    typedef struct packed {
        logic             legal;
        logic             end_stop;
        logic [NSLOT-1:0] mid_stop;
        utrip_t           unit;
    } tmpl_dec_t;

    function automatic utrip_t trip(unit_t s0, unit_t s1, unit_t s2);
        utrip_t r;
        r[0] = s0;
        r[1] = s1;
        r[2] = s2;
        return r;
    endfunction
endpackage

// File: rtl/bundle_tmpl_decode.sv
module bundle_tmpl_decode
    import disperse_pkg::*;
(
    input  logic [TMPL_W-1:0] tmpl,
    output tmpl_dec_t         dec
);
    always_comb begin
        dec          = '0;
        dec.legal    = 1'b1;
        dec.end_stop = tmpl[0];
        unique case (tmpl[TMPL_W-1:1])
            4'h0: dec.unit = trip(UT_M, UT_I, UT_I);
            4'h1: begin
                dec.unit     = trip(UT_M, UT_I, UT_I);
                dec.mid_stop = 3'b010;
            end
            4'h2: dec.unit = trip(UT_M, UT_L, UT_X);
            4'h4: dec.unit = trip(UT_M, UT_M, UT_I);
            4'h5: begin
                dec.unit     = trip(UT_M, UT_M, UT_I);
                dec.mid_stop = 3'b001;
            end
            4'h6: dec.unit = trip(UT_M, UT_F, UT_I);
            4'h7: dec.unit = trip(UT_M, UT_M, UT_F);
            4'h8: dec.unit = trip(UT_M, UT_I, UT_B);
            4'h9: dec.unit = trip(UT_M, UT_B, UT_B);
            4'hB: dec.unit = trip(UT_B, UT_B, UT_B);
            4'hC: dec.unit = trip(UT_M, UT_M, UT_B);
            4'hE: dec.unit = trip(UT_M, UT_F, UT_B);
            default: begin
                dec.legal    = 1'b0;
                dec.end_stop = 1'b0;
                dec.unit     = trip(UT_X, UT_X, UT_X);
            end
        endcase
    end
endmodule

// File: rtl/bundle_lane_router.sv
module bundle_lane_router
    import disperse_pkg::*;
(
    input  tmpl_dec_t                   dec,
    input  logic [NSLOT*SLOT_W-1:0]     slots,
    output logic [M_LANES-1:0]          m_v,
    output logic [M_LANES*SLOT_W-1:0]   m_d,
    output logic [M_LANES*IDX_W-1:0]    m_x,
    output logic [M_LANES-1:0]          m_s,
    output logic [I_LANES-1:0]          i_v,
    output logic [I_LANES*SLOT_W-1:0]   i_d,
    output logic [I_LANES*IDX_W-1:0]    i_x,
    output logic [I_LANES-1:0]          i_s,
    output logic                        f_v,
    output logic [SLOT_W-1:0]           f_d,
    output logic [IDX_W-1:0]            f_x,
    output logic                        f_s,
    output logic [B_LANES-1:0]          b_v,
    output logic [B_LANES*SLOT_W-1:0]   b_d,
    output logic [B_LANES*IDX_W-1:0]    b_x,
    output logic [B_LANES-1:0]          b_s,
    output logic                        l_v,
    output logic [2*SLOT_W-1:0]         l_d,
    output logic                        l_s
);
    always_comb begin
        logic [SLOT_W-1:0] sd;
        logic              st;
        int                nm;
        int                ni;
        int                nb;
        m_v = '0; m_d = '0; m_x = '0; m_s = '0;
        i_v = '0; i_d = '0; i_x = '0; i_s = '0;
        f_v = 1'b0; f_d = '0; f_x = '0; f_s = 1'b0;
        b_v = '0; b_d = '0; b_x = '0; b_s = '0;
        l_v = 1'b0; l_d = '0; l_s = 1'b0;
        nm = 0; ni = 0; nb = 0;
        for (int s = 0; s < NSLOT; s++) begin
            sd = slots[s*SLOT_W +: SLOT_W];
            st = dec.mid_stop[s] | ((s == NSLOT-1) && dec.end_stop);
            if (dec.legal) begin
                unique case (dec.unit[s])
                    UT_M: if (nm < M_LANES) begin
                        m_v[nm] = 1'b1;
                        m_d[nm*SLOT_W +: SLOT_W] = sd;
                        m_x[nm*IDX_W +: IDX_W]   = IDX_W'(s);
                        m_s[nm] = st;
                        nm++;
                    end
                    UT_I: if (ni < I_LANES) begin
                        i_v[ni] = 1'b1;
                        i_d[ni*SLOT_W +: SLOT_W] = sd;
                        i_x[ni*IDX_W +: IDX_W]   = IDX_W'(s);
                        i_s[ni] = st;
                        ni++;
                    end
                    UT_F: begin
                        f_v = 1'b1;
                        f_d = sd;
                        f_x = IDX_W'(s);
                        f_s = st;
                    end
                    UT_B: if (nb < B_LANES) begin
                        b_v[nb] = 1'b1;
                        b_d[nb*SLOT_W +: SLOT_W] = sd;
                        b_x[nb*IDX_W +: IDX_W]   = IDX_W'(s);
                        b_s[nb] = st;
                        nb++;
                    end
                    UT_L: if (s + 1 < NSLOT) begin
                        l_v = 1'b1;
                        l_d = {slots[(s+1)*SLOT_W +: SLOT_W], sd};
                        l_s = dec.end_stop;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/bundle_disperse.sv
module bundle_disperse
    import disperse_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [BUNDLE_W-1:0]         in_bundle,
    output logic                        bad_bundle,
    output logic [M_LANES-1:0]          mem_valid,
    input  logic                        mem_ready,
    output logic [M_LANES*SLOT_W-1:0]   mem_slot,
    output logic [M_LANES*IDX_W-1:0]    mem_idx,
    output logic [M_LANES-1:0]          mem_stop,
    output logic [I_LANES-1:0]          int_valid,
    input  logic                        int_ready,
    output logic [I_LANES*SLOT_W-1:0]   int_slot,
    output logic [I_LANES*IDX_W-1:0]    int_idx,
    output logic [I_LANES-1:0]          int_stop,
    output logic                        fp_valid,
    input  logic                        fp_ready,
    output logic [SLOT_W-1:0]           fp_slot,
    output logic [IDX_W-1:0]            fp_idx,
    output logic                        fp_stop,
    output logic [B_LANES-1:0]          br_valid,
    input  logic                        br_ready,
    output logic [B_LANES*SLOT_W-1:0]   br_slot,
    output logic [B_LANES*IDX_W-1:0]    br_idx,
    output logic [B_LANES-1:0]          br_stop,
    output logic                        lng_valid,
    input  logic                        lng_ready,
    output logic [2*SLOT_W-1:0]         lng_slot,
    output logic                        lng_stop
);
    typedef enum logic {ST_EMPTY, ST_LOADED} state_t;

    state_t    state_q, state_d;
    tmpl_dec_t dec;

    logic [M_LANES-1:0]        r_m_v;
    logic [M_LANES*SLOT_W-1:0] r_m_d;
    logic [M_LANES*IDX_W-1:0]  r_m_x;
    logic [M_LANES-1:0]        r_m_s;
    logic [I_LANES-1:0]        r_i_v;
    logic [I_LANES*SLOT_W-1:0] r_i_d;
    logic [I_LANES*IDX_W-1:0]  r_i_x;
    logic [I_LANES-1:0]        r_i_s;
    logic                      r_f_v;
    logic [SLOT_W-1:0]         r_f_d;
    logic [IDX_W-1:0]          r_f_x;
    logic                      r_f_s;
    logic [B_LANES-1:0]        r_b_v;
    logic [B_LANES*SLOT_W-1:0] r_b_d;
    logic [B_LANES*IDX_W-1:0]  r_b_x;
    logic [B_LANES-1:0]        r_b_s;
    logic                      r_l_v;
    logic [2*SLOT_W-1:0]       r_l_d;
    logic                      r_l_s;

    logic ports_ok, drain, accept;

    bundle_tmpl_decode u_dec (
        .tmpl (in_bundle[TMPL_W-1:0]),
        .dec  (dec)
    );

    bundle_lane_router u_route (
        .dec   (dec),
        .slots (in_bundle[BUNDLE_W-1:TMPL_W]),
        .m_v (r_m_v), .m_d (r_m_d), .m_x (r_m_x), .m_s (r_m_s),
        .i_v (r_i_v), .i_d (r_i_d), .i_x (r_i_x), .i_s (r_i_s),
        .f_v (r_f_v), .f_d (r_f_d), .f_x (r_f_x), .f_s (r_f_s),
        .b_v (r_b_v), .b_d (r_b_d), .b_x (r_b_x), .b_s (r_b_s),
        .l_v (r_l_v), .l_d (r_l_d), .l_s (r_l_s)
    );

    // A port blocks only when it carries a lane of the held bundle
    assign ports_ok = (~|mem_valid | mem_ready) & (~|int_valid | int_ready)
                    & (~fp_valid | fp_ready) & (~|br_valid | br_ready)
                    & (~lng_valid | lng_ready);
    assign drain    = (state_q == ST_LOADED) && ports_ok;
    assign in_ready = (state_q == ST_EMPTY) || drain;
    assign accept   = in_valid && in_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  if (accept && dec.legal) state_d = ST_LOADED;
            ST_LOADED: if (drain) state_d = (accept && dec.legal) ? ST_LOADED : ST_EMPTY;
            default:   state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_bundle <= 1'b0;
            mem_valid <= '0; mem_slot <= '0; mem_idx <= '0; mem_stop <= '0;
            int_valid <= '0; int_slot <= '0; int_idx <= '0; int_stop <= '0;
            fp_valid  <= 1'b0; fp_slot <= '0; fp_idx <= '0; fp_stop <= 1'b0;
            br_valid  <= '0; br_slot <= '0; br_idx <= '0; br_stop <= '0;
            lng_valid <= 1'b0; lng_slot <= '0; lng_stop <= 1'b0;
        end else if (accept) begin
            bad_bundle <= ~dec.legal;
            mem_valid <= r_m_v; mem_slot <= r_m_d; mem_idx <= r_m_x; mem_stop <= r_m_s;
            int_valid <= r_i_v; int_slot <= r_i_d; int_idx <= r_i_x; int_stop <= r_i_s;
            fp_valid  <= r_f_v; fp_slot  <= r_f_d; fp_idx  <= r_f_x; fp_stop  <= r_f_s;
            br_valid  <= r_b_v; br_slot  <= r_b_d; br_idx  <= r_b_x; br_stop  <= r_b_s;
            lng_valid <= r_l_v; lng_slot <= r_l_d; lng_stop <= r_l_s;
        end else begin
            bad_bundle <= 1'b0;
            if (drain) begin
                mem_valid <= '0; int_valid <= '0; fp_valid <= 1'b0;
                br_valid  <= '0; lng_valid <= 1'b0;
            end
        end
    end

    // ---------------- assertions ----------------
    logic any_out;
    assign any_out = |mem_valid | |int_valid | fp_valid | |br_valid | lng_valid;

    assert_illegal_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_bundle |-> !any_out);

    assert_one_cycle_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && dec.legal) |=> any_out);

    assert_hold_while_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (any_out && !ports_ok) |=> ($stable(mem_valid) && $stable(int_valid)
            && $stable(br_valid) && $stable(fp_valid) && $stable(lng_valid)
            && $stable(mem_slot) && $stable(int_slot) && $stable(br_slot)
            && $stable(fp_slot) && $stable(lng_slot)));

    assert_branch_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|br_valid && !br_ready) |-> !in_ready);

    assert_long_pair_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lng_valid |-> (mem_valid == 2'b01 && int_valid == '0 && br_valid == '0 && !fp_valid));

    assert_slot_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (any_out && !lng_valid) |-> ($countones({mem_valid, int_valid, fp_valid, br_valid}) == 3));

    assert_single_mid_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dec.legal |-> ($countones(dec.mid_stop) <= 1));
endmodule

// File: tb/bundle_disperse_tb_top.sv
module bundle_disperse_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic         in_valid = 1'b0, in_ready;
    logic [127:0] in_bundle = '0;
    logic         bad_bundle;
    logic [1:0]   mem_valid, mem_stop, int_valid, int_stop;
    logic [81:0]  mem_slot, int_slot, lng_slot;
    logic [3:0]   mem_idx, int_idx;
    logic         mem_ready = 1'b1, int_ready = 1'b1, fp_ready = 1'b1;
    logic         br_ready = 1'b1, lng_ready = 1'b1;
    logic         fp_valid, fp_stop, lng_valid, lng_stop;
    logic [40:0]  fp_slot;
    logic [1:0]   fp_idx;
    logic [2:0]   br_valid, br_stop;
    logic [122:0] br_slot;
    logic [5:0]   br_idx;

    bundle_disperse dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_bundle(in_bundle), .bad_bundle(bad_bundle),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_slot(mem_slot),
        .mem_idx(mem_idx), .mem_stop(mem_stop),
        .int_valid(int_valid), .int_ready(int_ready), .int_slot(int_slot),
        .int_idx(int_idx), .int_stop(int_stop),
        .fp_valid(fp_valid), .fp_ready(fp_ready), .fp_slot(fp_slot),
        .fp_idx(fp_idx), .fp_stop(fp_stop),
        .br_valid(br_valid), .br_ready(br_ready), .br_slot(br_slot),
        .br_idx(br_idx), .br_stop(br_stop),
        .lng_valid(lng_valid), .lng_ready(lng_ready), .lng_slot(lng_slot),
        .lng_stop(lng_stop)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // stimulus table: template codes, legal and reserved
    localparam logic [4:0] VEC [0:24] = '{
        5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h05, 5'h08, 5'h09, 5'h0A, 5'h0B,
        5'h0C, 5'h0D, 5'h0E, 5'h0F, 5'h10, 5'h11, 5'h12, 5'h13, 5'h16, 5'h17,
        5'h18, 5'h19, 5'h1C, 5'h1D, 5'h06 };

    // expected values
    logic        e_bad;
    logic [1:0]  e_mv, e_ms, e_iv, e_is;
    logic [81:0] e_md, e_id, e_ld;
    logic [3:0]  e_mx, e_ix;
    logic        e_fv, e_fs, e_lv, e_ls;
    logic [40:0] e_fd;
    logic [1:0]  e_fx;
    logic [2:0]  e_bv, e_bs;
    logic [122:0] e_bd;
    logic [5:0]  e_bx;

    function automatic logic [40:0] mkslot(input int v, input int k);
        return 41'((64'(v) << 32) | (64'(k) << 28) | 64'(32'h0ACE_1000 + v * 7 + k));
    endfunction

    // unit codes: 0 M, 1 I, 2 F, 3 B, 4 long pair, 5 second half of pair
    task automatic model(input logic [4:0] t, input logic [40:0] s0, s1, s2);
        int u [3];
        logic [2:0] mid;
        logic ok;
        logic [40:0] sv [3];
        int nm, ni, nb;
        logic st;
        sv[0] = s0; sv[1] = s1; sv[2] = s2;
        ok = 1'b1; mid = 3'b000;
        case (t)
            5'h00, 5'h01: u = '{0, 1, 1};
            5'h02, 5'h03: begin u = '{0, 1, 1}; mid = 3'b010; end
            5'h04, 5'h05: u = '{0, 4, 5};
            5'h08, 5'h09: u = '{0, 0, 1};
            5'h0A, 5'h0B: begin u = '{0, 0, 1}; mid = 3'b001; end
            5'h0C, 5'h0D: u = '{0, 2, 1};
            5'h0E, 5'h0F: u = '{0, 0, 2};
            5'h10, 5'h11: u = '{0, 1, 3};
            5'h12, 5'h13: u = '{0, 3, 3};
            5'h16, 5'h17: u = '{3, 3, 3};
            5'h18, 5'h19: u = '{0, 0, 3};
            5'h1C, 5'h1D: u = '{0, 2, 3};
            default: begin ok = 1'b0; u = '{5, 5, 5}; end
        endcase
        e_bad = ~ok;
        e_mv = 0; e_ms = 0; e_md = 0; e_mx = 0;
        e_iv = 0; e_is = 0; e_id = 0; e_ix = 0;
        e_fv = 0; e_fs = 0; e_fd = 0; e_fx = 0;
        e_bv = 0; e_bs = 0; e_bd = 0; e_bx = 0;
        e_lv = 0; e_ls = 0; e_ld = 0;
        nm = 0; ni = 0; nb = 0;
        for (int k = 0; k < 3; k++) begin
            st = mid[k] | (k == 2 && ok && t[0]);
            case (u[k])
                0: begin e_mv[nm] = 1; e_ms[nm] = st; e_md[nm*41 +: 41] = sv[k];
                         e_mx[nm*2 +: 2] = 2'(k); nm++; end
                1: begin e_iv[ni] = 1; e_is[ni] = st; e_id[ni*41 +: 41] = sv[k];
                         e_ix[ni*2 +: 2] = 2'(k); ni++; end
                2: begin e_fv = 1; e_fs = st; e_fd = sv[k]; e_fx = 2'(k); end
                3: begin e_bv[nb] = 1; e_bs[nb] = st; e_bd[nb*41 +: 41] = sv[k];
                         e_bx[nb*2 +: 2] = 2'(k); nb++; end
                4: begin e_lv = 1; e_ls = t[0]; e_ld = {s2, s1}; end
                default: ;
            endcase
        end
    endtask

    task automatic check_all(input string tag);
        chk("R6", {tag, " bad_bundle"}, 128'(bad_bundle), 128'(e_bad));
        chk("R2", {tag, " mem_valid"}, 128'(mem_valid), 128'(e_mv));
        chk("R2", {tag, " int_valid"}, 128'(int_valid), 128'(e_iv));
        chk("R2", {tag, " fp_valid"},  128'(fp_valid),  128'(e_fv));
        chk("R2", {tag, " br_valid"},  128'(br_valid),  128'(e_bv));
        chk("R1", {tag, " mem_slot"}, 128'(mem_slot), 128'(e_md));
        chk("R1", {tag, " int_slot"}, 128'(int_slot), 128'(e_id));
        chk("R1", {tag, " fp_slot"},  128'(fp_slot),  128'(e_fd));
        chk("R1", {tag, " br_slot"},  128'(br_slot),  128'(e_bd));
        chk("R3", {tag, " stops"}, 128'({mem_stop, int_stop, fp_stop, br_stop}),
            128'({e_ms, e_is, e_fs, e_bs}));
        chk("R5", {tag, " indices"}, 128'({mem_idx, int_idx, fp_idx, br_idx}),
            128'({e_mx, e_ix, e_fx, e_bx}));
        chk("R4", {tag, " long"}, 128'({lng_valid, lng_stop, lng_slot}),
            128'({e_lv, e_ls, e_ld}));
    endtask

    function automatic logic [127:0] mkbundle(input logic [4:0] t, input int v);
        return {mkslot(v, 2), mkslot(v, 1), mkslot(v, 0), t};
    endfunction

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: reset state
        chk("R9", "valids after reset", 128'({mem_valid, int_valid, fp_valid, br_valid, lng_valid}), 128'(0));
        chk("R9", "bad_bundle after reset", 128'(bad_bundle), 128'(0));
        chk("R9", "in_ready after reset", 128'(in_ready), 128'(1));

        // table walk: R1..R7
        for (int v = 0; v < 25; v++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_bundle = mkbundle(VEC[v], v + 1);
            model(VEC[v], mkslot(v + 1, 0), mkslot(v + 1, 1), mkslot(v + 1, 2));
            @(negedge clk);
            in_valid = 1'b0;
            // R7: visible one edge after acceptance
            check_all($sformatf("R7 code %h", VEC[v]));
        end

        // R6: reserved code drops the bundle, flag lasts one cycle
        @(negedge clk);
        in_valid = 1'b1; in_bundle = mkbundle(5'h1F, 90);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6", "reserved 1F flag", 128'(bad_bundle), 128'(1));
        chk("R6", "reserved 1F valids", 128'({mem_valid, int_valid, fp_valid, br_valid, lng_valid}), 128'(0));
        @(negedge clk);
        chk("R6", "flag one cycle", 128'(bad_bundle), 128'(0));
        chk("R6", "ready after drop", 128'(in_ready), 128'(1));

        // R8: stall on a used port, unused port ready ignored
        br_ready = 1'b0;
        in_valid = 1'b1; in_bundle = mkbundle(5'h17, 40);
        model(5'h17, mkslot(40, 0), mkslot(40, 1), mkslot(40, 2));
        @(negedge clk);
        check_all("R8 BBB loaded");
        chk("R8", "in_ready low while blocked", 128'(in_ready), 128'(0));
        in_bundle = mkbundle(5'h01, 41);
        @(negedge clk);
        check_all("R8 BBB held");
        chk("R8", "in_ready still low", 128'(in_ready), 128'(0));
        br_ready = 1'b1; mem_ready = 1'b0;
        #1;
        chk("R8", "unused mem_ready ignored", 128'(in_ready), 128'(1));
        model(5'h01, mkslot(41, 0), mkslot(41, 1), mkslot(41, 2));
        @(negedge clk);
        in_valid = 1'b0;
        check_all("R8 MII after drain");
        chk("R8", "in_ready low on mem block", 128'(in_ready), 128'(0));
        @(negedge clk);
        check_all("R8 MII held");
        mem_ready = 1'b1;
        @(negedge clk);
        chk("R8", "drained valids", 128'({mem_valid, int_valid, fp_valid, br_valid, lng_valid}), 128'(0));
        chk("R8", "ready after drain", 128'(in_ready), 128'(1));

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule